// File: doc/BRIEF.md
# Indirect Host Window Bridge with Ownership Semaphore

This block is an 8-bit slave port through which an external host reaches a shared packet buffer of up to 64 KB while using only four register locations. The host loads a 16-bit buffer pointer one byte at a time. It then moves bytes through a single data window, and the pointer advances after each window access. A fourth location holds the control and status bits. Through them the host can keep the on-chip MAC processor in reset, raise an interrupt to it, acknowledge an interrupt coming from it, and claim or release a hardware semaphore that decides who owns the buffer.

On the local side the bridge drives a synchronous single-port RAM interface: address, write enable, read enable and write data, with read data returned one cycle after the read enable. The MAC side has its own interrupt and semaphore handshake. Host strobes are single-cycle pulses that are synchronous to `clk_i`. A register read returns its data, together with `hst_rvalid_o`, in the cycle after the strobe.

Top module: `hwb_bridge`

## Requirements
- R1: After reset, the pointer is 0x0000, `mac_rst_o` is 1, `mac_irq_o`, `hst_irq_o`, `hst_rvalid_o` and `mac_sem_got_o` are 0, and the semaphore is free.
- R2: A write to address 0 loads the pointer's low byte and a write to address 1 loads its high byte. Reads of those addresses return the bytes on `hst_rdata_o` in the cycle after the strobe, with `hst_rvalid_o` high.
- R3: A write to address 2 asserts `ram_we_o` in the same cycle, with `ram_addr_o` equal to the pointer and `ram_wdata_o` equal to the host byte. The pointer then advances by one.
- R4: A read of address 2 asserts `ram_re_o` in the same cycle at the pointer address. `hst_rdata_o` carries `ram_rdata_i` in the next cycle, and the pointer advances by one.
- R5: Advancing the pointer from 0xFFFF gives 0x0000.
- R6: A strobe with `hst_cs_i` low has no effect. When read and write are strobed together, only the write takes place.
- R7: Control bit 0 (address 3) drives `mac_rst_o` directly and reads back its value.
- R8: Writing 1 to control bit 1 sets `mac_irq_o`, and writing 0 to it has no effect. A pulse on `mac_irq_clr_i` clears it. When the host sets the bit and the MAC clears it in the same cycle, the set wins. Bit 1 reads back the pending state.
- R9: A pulse on `mac_irq_set_i` sets `hst_irq_o`, which reads back as control bit 2. Writing 1 to bit 2 clears it. When the MAC sets the bit and the host clears it in the same cycle, the set wins.
- R10: Every read of address 3 returns the previous semaphore state in bit 3 and leaves the semaphore taken.
- R11: Writing address 3 with bit 3 at 0 releases the semaphore. Writing bit 3 as 1 leaves it unchanged.
- R12: A pulse on `mac_sem_take_i` gives `mac_sem_got_o` = 1 in the next cycle only if the semaphore was free and the host did not read address 3 in the same cycle. On success the semaphore becomes taken.
- R13: A pulse on `mac_sem_rel_i` releases the semaphore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_cs_i | input | 1 | Host chip enable |
| hst_addr_i | input | 2 | Host register select |
| hst_rd_i | input | 1 | Host read strobe |
| hst_wr_i | input | 1 | Host write strobe |
| hst_wdata_i | input | 8 | Host write data |
| hst_rdata_o | output | 8 | Host read data |
| hst_rvalid_o | output | 1 | Read data valid |
| hst_irq_o | output | 1 | Interrupt from MAC to host |
| ram_addr_o | output | 16 | Buffer RAM address |
| ram_we_o | output | 1 | Buffer RAM write enable |
| ram_re_o | output | 1 | Buffer RAM read enable |
| ram_wdata_o | output | 8 | Buffer RAM write data |
| ram_rdata_i | input | 8 | Buffer RAM read data (one cycle latency) |
| mac_rst_o | output | 1 | Reset to MAC processor |
| mac_irq_o | output | 1 | Interrupt from host to MAC |
| mac_irq_clr_i | input | 1 | MAC clears its pending interrupt |
| mac_irq_set_i | input | 1 | MAC raises host interrupt |
| mac_sem_take_i | input | 1 | MAC attempts to take semaphore |
| mac_sem_rel_i | input | 1 | MAC releases semaphore |
| mac_sem_got_o | output | 1 | MAC take succeeded (pulse) |

## Verification
Some behaviours are checked by assertions on every cycle: the pointer advancing by one on each window access, set-over-clear priority for both interrupt bits, the host winning a simultaneous semaphore take, read-valid timing, and silence on the RAM port while the chip enable is low. The bench scenarios are needed for everything that depends on data values. These are the byte contents that go through the window into a model RAM, wrap-around of the pointer at 0xFFFF, the test-and-set value returned to the host, and the fact that a write of 0 to the interrupt-request bit has no effect.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  typedef enum logic [1:0] {
    REG_PTR_LO = 2'd0,
    REG_PTR_HI = 2'd1,
    REG_DATA   = 2'd2,
    REG_CTRL   = 2'd3
  } hwb_reg_e;

  localparam int CTL_MRST = 0;
  localparam int CTL_H2M  = 1;
  localparam int CTL_M2H  = 2;
  localparam int CTL_SEM  = 3;
endpackage

// File: rtl/hwb_ptr.sv
module hwb_ptr #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 2,
  parameter int PTR_W  = DATA_W * NBYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NBYTES-1:0] ld_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              step_i,
  output logic [PTR_W-1:0]  ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (step_i) ptr_d = ptr_q + 1'b1;
    for (int b = 0; b < NBYTES; b++) begin
      if (ld_i[b]) ptr_d[b*DATA_W +: DATA_W] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R3 R4 R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> ptr_q == $past(ptr_q) + 1'b1);
endmodule

// File: rtl/hwb_sema.sv
module hwb_sema (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_take_i,
  input  logic host_rel_i,
  input  logic mac_take_i,
  input  logic mac_rel_i,
  output logic sem_o,
  output logic mac_got_o
);
  logic sem_q, sem_d, got_d, got_q;

  // host test-and-set beats a MAC take in the same cycle
  assign got_d = mac_take_i & ~sem_q & ~host_take_i;

  always_comb begin
    sem_d = sem_q;
    if (host_take_i)                  sem_d = 1'b1;
    else if (got_d)                   sem_d = 1'b1;
    else if (host_rel_i || mac_rel_i) sem_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sem_q <= 1'b0;
      got_q <= 1'b0;
    end else begin
      sem_q <= sem_d;
      got_q <= got_d;
    end
  end

  assign sem_o     = sem_q;
  assign mac_got_o = got_q;

  // R10
  host_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_take_i |=> sem_q);
  // R12
  host_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_take_i && mac_take_i) |=> !mac_got_o);
  // R12
  busy_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_take_i && sem_q) |=> !mac_got_o);
endmodule

// File: rtl/hwb_ctrl.sv
module hwb_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic mrst_val_i,
  input  logic h2m_set_i,
  input  logic m2h_clr_i,
  input  logic mac_irq_clr_i,
  input  logic mac_irq_set_i,
  output logic mac_rst_o,
  output logic h2m_o,
  output logic m2h_o
);
  logic mrst_q, h2m_q, m2h_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mrst_q <= 1'b1;
      h2m_q  <= 1'b0;
      m2h_q  <= 1'b0;
    end else begin
      if (wr_i) mrst_q <= mrst_val_i;
      if (h2m_set_i)          h2m_q <= 1'b1;
      else if (mac_irq_clr_i) h2m_q <= 1'b0;
      if (mac_irq_set_i)      m2h_q <= 1'b1;
      else if (m2h_clr_i)     m2h_q <= 1'b0;
    end
  end

  assign mac_rst_o = mrst_q;
  assign h2m_o     = h2m_q;
  assign m2h_o     = m2h_q;

  // R8
  h2m_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h2m_set_i |=> h2m_o);
  // R9
  m2h_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_irq_set_i |=> m2h_o);
  // R7
  mrst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mac_rst_o));
endmodule

// File: rtl/hwb_bridge.sv
module hwb_bridge
  import hwb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBYTES = 2,
  localparam int PTR_W = DATA_W * NBYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hst_cs_i,
  input  logic [1:0]        hst_addr_i,
  input  logic              hst_rd_i,
  input  logic              hst_wr_i,
  input  logic [DATA_W-1:0] hst_wdata_i,
  output logic [DATA_W-1:0] hst_rdata_o,
  output logic              hst_rvalid_o,
  output logic              hst_irq_o,
  output logic [PTR_W-1:0]  ram_addr_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              mac_rst_o,
  output logic              mac_irq_o,
  input  logic              mac_irq_clr_i,
  input  logic              mac_irq_set_i,
  input  logic              mac_sem_take_i,
  input  logic              mac_sem_rel_i,
  output logic              mac_sem_got_o
);
  logic wr_acc, rd_acc;
  logic sel_lo, sel_hi, sel_dat, sel_ctl;
  logic [NBYTES-1:0] ld;
  logic [PTR_W-1:0]  ptr;
  logic sem, h2m, m2h;
  logic rvalid_q, from_ram_q;
  logic [DATA_W-1:0] reg_q, reg_d, ctl_rd;

  // write takes precedence when both strobes arrive
  assign wr_acc  = hst_cs_i & hst_wr_i;
  assign rd_acc  = hst_cs_i & hst_rd_i & ~hst_wr_i;
  assign sel_lo  = hst_addr_i == REG_PTR_LO;
  assign sel_hi  = hst_addr_i == REG_PTR_HI;
  assign sel_dat = hst_addr_i == REG_DATA;
  assign sel_ctl = hst_addr_i == REG_CTRL;

  always_comb begin
    ld = '0;
    ld[0]        = wr_acc & sel_lo;
    ld[NBYTES-1] = wr_acc & sel_hi;
  end

  assign ram_we_o    = wr_acc & sel_dat;
  assign ram_re_o    = rd_acc & sel_dat;
  assign ram_addr_o  = ptr;
  assign ram_wdata_o = hst_wdata_i;

  hwb_ptr #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (ld),
    .wdata_i (hst_wdata_i),
    .step_i  (ram_we_o | ram_re_o),
    .ptr_o   (ptr)
  );

  hwb_sema u_sema (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_take_i (rd_acc & sel_ctl),
    .host_rel_i  (wr_acc & sel_ctl & ~hst_wdata_i[CTL_SEM]),
    .mac_take_i  (mac_sem_take_i),
    .mac_rel_i   (mac_sem_rel_i),
    .sem_o       (sem),
    .mac_got_o   (mac_sem_got_o)
  );

  hwb_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_acc & sel_ctl),
    .mrst_val_i    (hst_wdata_i[CTL_MRST]),
    .h2m_set_i     (wr_acc & sel_ctl & hst_wdata_i[CTL_H2M]),
    .m2h_clr_i     (wr_acc & sel_ctl & hst_wdata_i[CTL_M2H]),
    .mac_irq_clr_i (mac_irq_clr_i),
    .mac_irq_set_i (mac_irq_set_i),
    .mac_rst_o     (mac_rst_o),
    .h2m_o         (h2m),
    .m2h_o         (m2h)
  );

  always_comb begin
    ctl_rd           = '0;
    ctl_rd[CTL_MRST] = mac_rst_o;
    ctl_rd[CTL_H2M]  = h2m;
    ctl_rd[CTL_M2H]  = m2h;
    ctl_rd[CTL_SEM]  = sem;
  end

  always_comb begin
    unique case (hst_addr_i)
      REG_PTR_LO: reg_d = ptr[DATA_W-1:0];
      REG_PTR_HI: reg_d = ptr[PTR_W-1 -: DATA_W];
      REG_CTRL:   reg_d = ctl_rd;
      default:    reg_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q   <= 1'b0;
      from_ram_q <= 1'b0;
      reg_q      <= '0;
    end else begin
      rvalid_q   <= rd_acc;
      from_ram_q <= rd_acc & sel_dat;
      if (rd_acc) reg_q <= reg_d;
    end
  end

  assign hst_rdata_o  = from_ram_q ? ram_rdata_i : reg_q;
  assign hst_rvalid_o = rvalid_q;
  assign hst_irq_o    = m2h;
  assign mac_irq_o    = h2m;

  // R6
  no_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hst_cs_i |-> !ram_we_o && !ram_re_o);
  // R4
  rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |=> hst_rvalid_o);
  // R6
  wr_over_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_cs_i && hst_wr_i && hst_rd_i) |=> !hst_rvalid_o);
endmodule

// File: tb/hwb_bridge_test.sv
`timescale 1ns/1ps
module hwb_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic rvalid, hirq;
  logic [15:0] raddr;
  logic rwe, rre;
  logic [7:0] rwdata, rrdata;
  logic mrst, mirq;
  logic mclr = 1'b0, mset = 1'b0, mtake = 1'b0, mrel = 1'b0;
  logic mgot;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hwb_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .hst_cs_i(cs), .hst_addr_i(addr),
    .hst_rd_i(rd), .hst_wr_i(wr), .hst_wdata_i(wdata), .hst_rdata_o(rdata),
    .hst_rvalid_o(rvalid), .hst_irq_o(hirq), .ram_addr_o(raddr),
    .ram_we_o(rwe), .ram_re_o(rre), .ram_wdata_o(rwdata), .ram_rdata_i(rrdata),
    .mac_rst_o(mrst), .mac_irq_o(mirq), .mac_irq_clr_i(mclr),
    .mac_irq_set_i(mset), .mac_sem_take_i(mtake), .mac_sem_rel_i(mrel),
    .mac_sem_got_o(mgot)
  );

  // model RAM, low address byte only, one cycle read latency
  logic [7:0] mem [256];
  always_ff @(posedge clk) begin
    if (rwe) mem[raddr[7:0]] <= rwdata;
    if (rre) rrdata <= mem[raddr[7:0]];
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic c, input logic r, input logic w,
                     input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = c; rd = r; wr = w; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; rd = 0; wr = 0;
  endtask

  task automatic hw(input logic [1:0] a, input logic [7:0] d);
    bus(1'b1, 1'b0, 1'b1, a, d);
  endtask

  task automatic hr(input logic [1:0] a, output logic [7:0] d);
    bus(1'b1, 1'b1, 1'b0, a, 8'h00);
    d = rvalid ? rdata : 8'hxx;
  endtask

  // {is_read, addr, data, expected}
  localparam int NV = 17;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h10, 8'h00},  // R2 ptr lo
    {1'b0, 2'd1, 8'h00, 8'h00},  // R2 ptr hi
    {1'b0, 2'd2, 8'hAA, 8'h00},  // R3
    {1'b0, 2'd2, 8'hBB, 8'h00},  // R3
    {1'b1, 2'd0, 8'h00, 8'h12},  // R3 advanced twice
    {1'b1, 2'd1, 8'h00, 8'h00},  // R2
    {1'b0, 2'd0, 8'h10, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'hAA},  // R4
    {1'b1, 2'd2, 8'h00, 8'hBB},  // R4
    {1'b1, 2'd0, 8'h00, 8'h12},  // R4 advance
    {1'b1, 2'd3, 8'h00, 8'h01},  // R10 old 0, reset held
    {1'b1, 2'd3, 8'h00, 8'h09},  // R10 old 1
    {1'b0, 2'd3, 8'h00, 8'h00},  // R7 R11
    {1'b1, 2'd3, 8'h00, 8'h00},  // R11 released
    {1'b0, 2'd3, 8'h00, 8'h00},
    {1'b0, 2'd1, 8'h3C, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'h3C}   // R2
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 mac_rst", {7'd0, mrst}, 8'h01);
    check("R1 mac_irq", {7'd0, mirq}, 8'h00);
    check("R1 hst_irq", {7'd0, hirq}, 8'h00);
    check("R1 rvalid", {7'd0, rvalid}, 8'h00);
    check("R1 sem_got", {7'd0, mgot}, 8'h00);
    hr(2'd0, v); check("R1 ptr lo", v, 8'h00);
    hr(2'd1, v); check("R1 ptr hi", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) begin
        hr(VEC[i][17:16], v);
        check($sformatf("R2/R4/R10 vec %0d", i), v, VEC[i][7:0]);
      end else begin
        hw(VEC[i][17:16], VEC[i][15:8]);
      end
    end

    // R5 wrap on write, then on read
    hw(2'd0, 8'hFF); hw(2'd1, 8'hFF); hw(2'd2, 8'h5E);
    hr(2'd0, v); check("R5 lo after wr", v, 8'h00);
    hr(2'd1, v); check("R5 hi after wr", v, 8'h00);
    hw(2'd0, 8'hFF); hw(2'd1, 8'hFF);
    hr(2'd2, v); check("R5 data at FFFF", v, 8'h5E);
    hr(2'd1, v); check("R5 hi after rd", v, 8'h00);

    // R6 no chip enable
    bus(1'b0, 1'b0, 1'b1, 2'd0, 8'h44);
    hr(2'd0, v); check("R6 cs low ignored", v, 8'h00);
    // R6 simultaneous strobes
    @(negedge clk);
    cs = 1; rd = 1; wr = 1; addr = 2'd2; wdata = 8'h77;
    #1;
    check("R6 both: re", {7'd0, rre}, 8'h00);
    check("R6 both: we", {7'd0, rwe}, 8'h01);
    @(negedge clk);
    cs = 0; rd = 0; wr = 0;
    check("R6 both: no rvalid", {7'd0, rvalid}, 8'h00);
    hr(2'd0, v); check("R6 single step", v, 8'h01);
    hw(2'd0, 8'h00);
    hr(2'd2, v); check("R6 write landed", v, 8'h77);

    // R7
    hw(2'd3, 8'h01);
    check("R7 reset set", {7'd0, mrst}, 8'h01);
    hw(2'd3, 8'h00);
    check("R7 reset clr", {7'd0, mrst}, 8'h00);

    // R8
    hw(2'd3, 8'h02);
    check("R8 set", {7'd0, mirq}, 8'h01);
    hw(2'd3, 8'h00);
    check("R8 write0 no effect", {7'd0, mirq}, 8'h01);
    @(negedge clk); mclr = 1; @(negedge clk); mclr = 0;
    check("R8 mac clear", {7'd0, mirq}, 8'h00);
    @(negedge clk);
    cs = 1; wr = 1; addr = 2'd3; wdata = 8'h02; mclr = 1;
    @(negedge clk);
    cs = 0; wr = 0; mclr = 0;
    check("R8 set wins", {7'd0, mirq}, 8'h01);
    @(negedge clk); mclr = 1; @(negedge clk); mclr = 0;

    // R9
    @(negedge clk); mset = 1; @(negedge clk); mset = 0;
    check("R9 set", {7'd0, hirq}, 8'h01);
    hr(2'd3, v); check("R9 status bit", v & 8'h04, 8'h04);
    hw(2'd3, 8'h04);
    check("R9 host clear", {7'd0, hirq}, 8'h00);
    @(negedge clk);
    cs = 1; wr = 1; addr = 2'd3; wdata = 8'h04; mset = 1;
    @(negedge clk);
    cs = 0; wr = 0; mset = 0;
    check("R9 set wins", {7'd0, hirq}, 8'h01);
    hw(2'd3, 8'h04);

    // R11 write 1 keeps, write 0 frees
    hr(2'd3, v);
    hw(2'd3, 8'h08);
    hr(2'd3, v); check("R11 write1 keeps", v & 8'h08, 8'h08);
    hw(2'd3, 8'h00);

    // R12 MAC take when free
    @(negedge clk); mtake = 1; @(negedge clk); mtake = 0;
    check("R12 mac got", {7'd0, mgot}, 8'h01);
    @(negedge clk); mtake = 1; @(negedge clk); mtake = 0;
    check("R12 busy fails", {7'd0, mgot}, 8'h00);
    hr(2'd3, v); check("R12 host sees taken", v & 8'h08, 8'h08);
    // R13
    @(negedge clk); mrel = 1; @(negedge clk); mrel = 0;
    hr(2'd3, v); check("R13 released", v & 8'h08, 8'h00);
    hw(2'd3, 8'h00);
    // R12 tie: host wins
    @(negedge clk);
    cs = 1; rd = 1; addr = 2'd3; mtake = 1;
    @(negedge clk);
    cs = 0; rd = 0; mtake = 0;
    check("R12 tie host old", rdata & 8'h08, 8'h00);
    check("R12 tie mac loses", {7'd0, mgot}, 8'h00);
    hr(2'd3, v); check("R12 host owns", v & 8'h08, 8'h08);
    hw(2'd3, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule